// File: doc/BRIEF.md
# Security-Partitioned Four-Way Cache Data Array

This block is the data storage of a four-way set-associative cache whose ways are split by security level. Ways 0 and 1 form the public partition and ways 2 and 3 form the secret partition. Each request carries a level bit, a way number, a set index, a tag and, for writes, data. Writes land in exactly one way. Reads are registered and return one cycle later together with a hit flag and the number of the way that answered.

Each way keeps a valid bit and an 8-bit tag for every entry. For secret reads the way is picked from the hit signals of the two secret ways, so the requester need not know where a line lives. A public read always uses the way it names.

Isolation is structural. A request whose level does not match the partition of its named way is refused. It writes nothing and raises an error pulse. Secret traffic therefore can never modify a public entry, and the public ways hold only what public requests put there.

Top module: `part_cache_array`

## Requirements
- R1: An accepted write to way W (`req_way`, 0..3) at index I stores the data and tag in way W at index I and marks that entry valid. All entries of the other three ways, and all other indices of way W, are unchanged.
- R2: An accepted read raises `rsp_valid` for one cycle, on the clock edge after the one that sampled the request. It returns data, hit and way on that same edge. Writes and refused requests leave `rsp_valid` low.
- R3: A synchronous active-high reset clears every valid bit and drives `rsp_valid` and `rsp_err` low. A read of an invalid entry returns `rsp_hit` = 0 and `rsp_data` = 0.
- R4: A way hits when its entry at the index is valid and its stored tag equals `req_tag`. A read that does not hit returns zero data.
- R5: A public request (`req_secure` = 0) naming way 2 or 3 is refused. Nothing is written, and `rsp_err` is high for exactly the one cycle after the request while `rsp_valid` stays low.
- R6: A secret request (`req_secure` = 1) naming way 0 or 1 is refused in the same way as in R5.
- R7: An accepted secret read ignores `req_way` bit 0 and picks way 2 if way 2 hits, else way 3 if way 3 hits, else way 2. `rsp_way` reports the chosen way.
- R8: When ways 2 and 3 both hit on a secret read, way 2 is chosen.
- R9: A public read uses the way it names (0 or 1) directly, and `rsp_way` equals that way.
- R10: No secret request, accepted or refused, changes any public-way entry. Public read results are the same whether or not secret traffic took place between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = secret level, 0 = public level |
| req_way | input | 2 | Named way, 0..3 |
| req_index | input | 8 | Set index |
| req_tag | input | 8 | Tag to store or compare |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read result valid |
| rsp_data | output | 32 | Read data, zero on miss |
| rsp_hit | output | 1 | Read hit |
| rsp_way | output | 2 | Way that answered the read |
| rsp_err | output | 1 | Pulse for a refused request |

## Verification
Public reads are tried with matching tags, wrong tags and never-written indices. These patterns separate a real hit from a stale or invalid entry. Secret reads are tried with a hit only in way 3, a hit only in way 2, hits in both and hits in neither, which tells apart each branch of the way choice and its priority. Level-mismatched writes in both directions are followed by reads of the targeted entry to show that nothing was stored. Public entries are read, then secret reads, writes and refused writes are aimed at the same indices and tags, and the public entries are read again to expose any leak from the secret side.

// File: rtl/part_cache_array.sv
module part_cache_array #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic                     req_secure,
  input  logic [1:0]               req_way,
  input  logic [$clog2(DEPTH)-1:0] req_index,
  input  logic [TAG_W-1:0]         req_tag,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_data,
  output logic                     rsp_hit,
  output logic [1:0]               rsp_way,
  output logic                     rsp_err
);
  localparam int WAYS = 4;

  logic [DATA_W-1:0] mem   [WAYS][DEPTH];
  logic [TAG_W-1:0]  tag_q [WAYS][DEPTH];
  logic [DEPTH-1:0]  vld_q [WAYS];
  logic [WAYS-1:0]   hit;

  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : g_hit
      assign hit[w] = vld_q[w][req_index] && (tag_q[w][req_index] == req_tag);
    end
  endgenerate

  wire       refuse  = req_valid && (req_secure != req_way[1]);
  wire       accept  = req_valid && !refuse;
  wire       do_wr   = accept && req_write;
  wire       do_rd   = accept && !req_write;
  wire [1:0] sec_way = (hit[2] || !hit[3]) ? 2'd2 : 2'd3;
  wire [1:0] rd_way  = req_secure ? sec_way : req_way;

  always_ff @(posedge clk) begin
    for (int i = 0; i < WAYS; i++) begin
      if (do_wr && req_way == 2'(i)) begin
        mem[i][req_index]   <= req_wdata;
        tag_q[i][req_index] <= req_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WAYS; i++) vld_q[i] <= '0;
    end else begin
      for (int i = 0; i < WAYS; i++)
        if (do_wr && req_way == 2'(i)) vld_q[i][req_index] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= 2'd0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= do_rd;
      rsp_err   <= refuse;
      if (do_rd) begin
        rsp_way  <= rd_way;
        rsp_hit  <= hit[rd_way];
        rsp_data <= hit[rd_way] ? mem[rd_way][req_index] : '0;
      end
    end
  end

  a_r2_read_latency: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && (req_secure == req_way[1])) |=> rsp_valid);

  a_r3_miss_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_data == '0));

  a_r5_public_high_refused: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_secure && req_way[1]) |=> (rsp_err && !rsp_valid));

  a_r6_secret_low_refused: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_secure && !req_way[1]) |=> (rsp_err && !rsp_valid));

  a_r7_way3_only: assert property (@(posedge clk) disable iff (rst)
    (do_rd && req_secure && hit[3] && !hit[2]) |=> (rsp_way == 2'd3 && rsp_hit));

  a_r8_way2_priority: assert property (@(posedge clk) disable iff (rst)
    (do_rd && req_secure && hit[2] && hit[3]) |=> (rsp_way == 2'd2));

  a_r9_public_named_way: assert property (@(posedge clk) disable iff (rst)
    (do_rd && !req_secure) |=> (rsp_way == $past(req_way)));

  a_r10_public_valid_stable: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_secure) |=> ($stable(vld_q[0]) && $stable(vld_q[1])));

  a_r5_err_excludes_valid: assert property (@(posedge clk) disable iff (rst)
    !(rsp_err && rsp_valid));
endmodule

// File: tb/part_cache_array_tb.sv
module part_cache_array_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, req_secure;
  logic [1:0]  req_way;
  logic [7:0]  req_index, req_tag;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_hit, rsp_err;
  logic [31:0] rsp_data;
  logic [1:0]  rsp_way;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  part_cache_array dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_secure(req_secure), .req_way(req_way), .req_index(req_index),
    .req_tag(req_tag), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_err(rsp_err)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic sec, input logic wr, input logic [1:0] way,
                       input logic [7:0] idx, input logic [7:0] tag, input logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_secure = sec; req_write = wr;
    req_way = way; req_index = idx; req_tag = tag; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_read(input string req, input logic hit, input logic [1:0] way, input logic [31:0] data);
    check(req, "rsp_valid", 32'(rsp_valid), 32'd1);
    check(req, "rsp_err", 32'(rsp_err), 32'd0);
    check(req, "rsp_hit", 32'(hit ? rsp_hit : rsp_hit), 32'(hit));
    check(req, "rsp_way", 32'(rsp_way), 32'(way));
    check(req, "rsp_data", rsp_data, data);
  endtask

  task automatic do_reset();
    rst = 1'b1; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R3", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check("R3", "rsp_err after reset", 32'(rsp_err), 32'd0);
    issue(0, 0, 2'd0, 8'd5, 8'd0, 0);
    expect_read("R3", 0, 2'd0, 32'd0);
    issue(1, 0, 2'd2, 8'd5, 8'd0, 0);
    expect_read("R3", 0, 2'd2, 32'd0);
  endtask

  task automatic t_public_rw();
    issue(0, 1, 2'd0, 8'd10, 8'h11, 32'hAAAA_0001);
    check("R2", "no rsp_valid on write", 32'(rsp_valid), 32'd0);
    issue(0, 1, 2'd1, 8'd10, 8'h22, 32'hBBBB_0002);
    issue(0, 0, 2'd0, 8'd10, 8'h11, 0);
    expect_read("R1", 1, 2'd0, 32'hAAAA_0001);
    @(negedge clk);
    check("R2", "rsp_valid one cycle only", 32'(rsp_valid), 32'd0);
    issue(0, 0, 2'd1, 8'd10, 8'h22, 0);
    expect_read("R9", 1, 2'd1, 32'hBBBB_0002);
    issue(0, 1, 2'd0, 8'd11, 8'h11, 32'hCCCC_0003);
    issue(0, 0, 2'd0, 8'd10, 8'h11, 0);
    expect_read("R1", 1, 2'd0, 32'hAAAA_0001);
    issue(0, 0, 2'd1, 8'd11, 8'h11, 0);
    expect_read("R1", 0, 2'd1, 32'd0);
  endtask

  task automatic t_tag_miss();
    issue(0, 0, 2'd0, 8'd10, 8'h12, 0);
    expect_read("R4", 0, 2'd0, 32'd0);
  endtask

  task automatic t_refuse_public_high();
    issue(0, 1, 2'd2, 8'd20, 8'h77, 32'hDEAD_0004);
    check("R5", "rsp_err", 32'(rsp_err), 32'd1);
    check("R5", "rsp_valid", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    check("R5", "rsp_err one cycle", 32'(rsp_err), 32'd0);
    issue(1, 0, 2'd2, 8'd20, 8'h77, 0);
    expect_read("R5", 0, 2'd2, 32'd0);
    issue(0, 0, 2'd3, 8'd20, 8'h77, 0);
    check("R5", "read refused err", 32'(rsp_err), 32'd1);
    check("R5", "read refused valid", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_refuse_secret_low();
    issue(1, 1, 2'd0, 8'd10, 8'h11, 32'hBAD0_0005);
    check("R6", "rsp_err", 32'(rsp_err), 32'd1);
    check("R6", "rsp_valid", 32'(rsp_valid), 32'd0);
    issue(0, 0, 2'd0, 8'd10, 8'h11, 0);
    expect_read("R6", 1, 2'd0, 32'hAAAA_0001);
  endtask

  task automatic t_secret_select();
    issue(1, 1, 2'd3, 8'd30, 8'h33, 32'hEEEE_0006);
    issue(1, 0, 2'd2, 8'd30, 8'h33, 0);
    expect_read("R7", 1, 2'd3, 32'hEEEE_0006);
    issue(1, 0, 2'd3, 8'd30, 8'h44, 0);
    expect_read("R7", 0, 2'd2, 32'd0);
    issue(1, 1, 2'd2, 8'd30, 8'h55, 32'hFFFF_0007);
    issue(1, 0, 2'd3, 8'd30, 8'h55, 0);
    expect_read("R7", 1, 2'd2, 32'hFFFF_0007);
  endtask

  task automatic t_both_hit();
    issue(1, 1, 2'd2, 8'd40, 8'h66, 32'h1234_0008);
    issue(1, 1, 2'd3, 8'd40, 8'h66, 32'h5678_0009);
    issue(1, 0, 2'd3, 8'd40, 8'h66, 0);
    expect_read("R8", 1, 2'd2, 32'h1234_0008);
  endtask

  task automatic t_isolation();
    for (int k = 0; k < 4; k++)
      issue(0, 1, 2'(k % 2), 8'(50 + k), 8'(8'h90 + k), 32'h0C0D_0000 + 32'(k));
    for (int k = 0; k < 4; k++) begin
      issue(1, 1, 2'd2 + 2'(k % 2), 8'(50 + k), 8'(8'h90 + k), 32'h5EC0_0000 + 32'(k));
      issue(1, 1, 2'(k % 2), 8'(50 + k), 8'(8'h90 + k), 32'h5EC1_0000 + 32'(k));
      issue(1, 0, 2'd2, 8'(50 + k), 8'(8'h90 + k), 0);
    end
    for (int k = 0; k < 4; k++) begin
      issue(0, 0, 2'(k % 2), 8'(50 + k), 8'(8'h90 + k), 0);
      expect_read("R10", 1, 2'(k % 2), 32'h0C0D_0000 + 32'(k));
    end
  endtask

  task automatic t_reset_clears();
    do_reset();
    issue(0, 0, 2'd0, 8'd10, 8'h11, 0);
    expect_read("R3", 0, 2'd0, 32'd0);
    issue(1, 0, 2'd2, 8'd40, 8'h66, 0);
    expect_read("R3", 0, 2'd2, 32'd0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_secure = 1'b0;
    req_way = '0; req_index = '0; req_tag = '0; req_wdata = '0;
    t_reset_state();
    t_public_rw();
    t_tag_miss();
    t_refuse_public_high();
    t_refuse_secret_low();
    t_secret_select();
    t_both_hit();
    t_isolation();
    t_reset_clears();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule